// File: doc/BRIEF.md
# DMA Command Element Executor

This block sits behind a DMA channel and carries out register-level commands. Each command is a fixed group of four 32-bit words that arrives on a valid/ready stream. A write command changes a peripheral register under a bit mask. A read command fetches a peripheral register and stores the value in system memory. The memory destination address can be up to 36 bits wide.

The peripheral side is a request/acknowledge bus that carries both reads and writes. The memory side is a write-only request/acknowledge port with a 36-bit address. The block handles one element at a time. It pulses `done` when an element is retired. An opcode it does not recognise sets a sticky error flag.

A static mode input chooses how the third word of a read is used. In legacy mode that word is ignored. In extended mode its low nibble supplies the top four destination address bits.

Top module: `cmd_elem_exec`

## Requirements
- R1: Words are accepted when `in_valid` and `in_ready` are both high, in the order word0, word1, word2, word3. `in_ready` is high after reset. It falls once word3 is accepted and stays low until the cycle after the `done` pulse for that element.
- R2: The opcode is word0[31:24], where 0 means write and 1 means read. The peripheral address is word0[23:0]. This address appears unchanged on `pb_addr` for every bus access of the element, whatever word2 holds.
- R3: For a write whose mask (word2) is not all ones, the block first reads the register at that address. It then writes back (old & ~mask) | (word1 & mask).
- R4: For a write whose mask is all ones, no peripheral read takes place. Exactly one write of word1 is issued.
- R5: For a read, the block performs one peripheral read and then one memory write. The memory write carries the value read, and `mw_addr[31:0]` equals word1. No peripheral write takes place.
- R6: In extended mode (`ext_addr_mode`=1), `mw_addr[35:32]` of a read equals word2[3:0]. Word2[31:4] has no effect.
- R7: In legacy mode (`ext_addr_mode`=0), `mw_addr[35:32]` is zero. Word2 of a read has no effect.
- R8: Word3 has no effect on any access for either opcode.
- R9: An opcode other than 0 or 1 makes no peripheral or memory access and sets `err`. `err` stays high until reset. The element still ends with a `done` pulse.
- R10: Each element produces exactly one `done` pulse, and that pulse lasts one cycle.
- R11: The mode is sampled when word0 is accepted. A change to `ext_addr_mode` after that does not affect the element in progress.
- R12: A request on either port, together with its address, write flag and data, stays stable until it is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_addr_mode | input | 1 | 1: word2[3:0] supplies destination bits 35:32 of a read |
| in_data | input | 32 | Command word |
| in_valid | input | 1 | Command word present |
| in_ready | output | 1 | Block accepts a word |
| pb_req | output | 1 | Peripheral access request |
| pb_we | output | 1 | 1 for a write, 0 for a read |
| pb_addr | output | 24 | Peripheral register address |
| pb_wdata | output | 32 | Peripheral write data |
| pb_rdata | input | 32 | Peripheral read data, valid with `pb_ack` |
| pb_ack | input | 1 | Peripheral access complete |
| mw_req | output | 1 | Memory write request |
| mw_addr | output | 36 | Memory write address |
| mw_data | output | 32 | Memory write data |
| mw_ack | input | 1 | Memory write complete |
| done | output | 1 | One-cycle pulse when an element retires |
| err | output | 1 | Sticky flag for an unknown opcode |

## Verification
The bench targets these corner cases:
- A mask of all ones. A design that always does a read-modify-write would show an extra read.
- A mask of zero. A design that skips the write here would change the access count.
- Read elements whose word2 has junk in its upper bits, in both modes. A design that decodes too many bits would leak them into the high address, and one that ignores the mode would put nonzero upper bits on a legacy read.
- Opcodes 2 and 0xFF. These must produce no bus activity and still retire.
- A mode change just after word0 is accepted. A design that samples the mode late would pick up the new mode.
- The same element sent twice with different word3 values. The outputs must be identical.

// File: rtl/cex_pkg.sv
package cex_pkg;

  localparam int CE_WORDS = 4;
  localparam int OP_W     = 8;

  localparam logic [OP_W-1:0] OP_WRITE = 8'd0;
  localparam logic [OP_W-1:0] OP_READ  = 8'd1;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRD,
    ST_PWR,
    ST_MWR,
    ST_DONE
  } cex_state_t;

endpackage

// File: rtl/cex_gather.sv
module cex_gather
  import cex_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int PADDR_W = 24
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ext_mode_i,
  input  logic [DATA_W-1:0]  in_data,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic               release_i,
  output logic               elem_valid_o,
  output logic [OP_W-1:0]    op_o,
  output logic [PADDR_W-1:0] paddr_o,
  output logic [DATA_W-1:0]  w1_o,
  output logic [DATA_W-1:0]  w2_o,
  output logic               mode_o
);

  localparam int CNT_W = $clog2(CE_WORDS);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CE_WORDS - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             full_q, full_d;
  logic             accept;
  logic             ld_w0, ld_w1, ld_w2;

  assign in_ready = !full_q;
  assign accept   = in_valid && in_ready;

  // next-state
  always_comb begin
    cnt_d  = cnt_q;
    full_d = full_q;
    ld_w0  = 1'b0;
    ld_w1  = 1'b0;
    ld_w2  = 1'b0;
    if (accept) begin
      ld_w0 = (cnt_q == CNT_W'(0));
      ld_w1 = (cnt_q == CNT_W'(1));
      ld_w2 = (cnt_q == CNT_W'(2));
      if (cnt_q == LAST) begin
        cnt_d  = '0;
        full_d = 1'b1;
      end else begin
        cnt_d = cnt_q + CNT_W'(1);
      end
    end else if (release_i) begin
      full_d = 1'b0;
    end
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      full_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      full_q <= full_d;
    end
  end

  // field registers, no reset, explicit enables
  always_ff @(posedge clk) begin
    if (ld_w0) begin
      op_o    <= in_data[DATA_W-1 -: OP_W];
      paddr_o <= in_data[PADDR_W-1:0];
      mode_o  <= ext_mode_i;
    end
    if (ld_w1) w1_o <= in_data;
    if (ld_w2) w2_o <= in_data;
  end

  assign elem_valid_o = full_q;

  AST_ELEM_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    full_q && !release_i |=> full_q && $stable(op_o) && $stable(w1_o)); // R1

endmodule

// File: rtl/cex_exec.sv
module cex_exec
  import cex_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int PADDR_W = 24,
  parameter int MADDR_W = 36
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               elem_valid_i,
  input  logic [OP_W-1:0]    op_i,
  input  logic [PADDR_W-1:0] paddr_i,
  input  logic [DATA_W-1:0]  w1_i,
  input  logic [DATA_W-1:0]  w2_i,
  input  logic               mode_i,
  output logic               pb_req,
  output logic               pb_we,
  output logic [PADDR_W-1:0] pb_addr,
  output logic [DATA_W-1:0]  pb_wdata,
  input  logic [DATA_W-1:0]  pb_rdata,
  input  logic               pb_ack,
  output logic               mw_req,
  output logic [MADDR_W-1:0] mw_addr,
  output logic [DATA_W-1:0]  mw_data,
  input  logic               mw_ack,
  output logic               release_o,
  output logic               done,
  output logic               err
);

  localparam int HI_W = MADDR_W - DATA_W;

  cex_state_t        state_q, state_d;
  logic [DATA_W-1:0] val_q, val_d;
  logic              val_en;
  logic              err_q, err_d;

  function automatic logic [DATA_W-1:0] merge_bits(
    input logic [DATA_W-1:0] old_v,
    input logic [DATA_W-1:0] new_v,
    input logic [DATA_W-1:0] msk);
    return (old_v & ~msk) | (new_v & msk);
  endfunction

  // next-state
  always_comb begin
    state_d = state_q;
    val_d   = val_q;
    val_en  = 1'b0;
    err_d   = err_q;
    unique case (state_q)
      ST_IDLE: if (elem_valid_i) begin
        if (op_i == OP_WRITE) begin
          if (&w2_i) begin
            state_d = ST_PWR;
            val_en  = 1'b1;
            val_d   = w1_i;
          end else begin
            state_d = ST_PRD;
          end
        end else if (op_i == OP_READ) begin
          state_d = ST_PRD;
        end else begin
          err_d   = 1'b1;
          state_d = ST_DONE;
        end
      end
      ST_PRD: if (pb_ack) begin
        val_en = 1'b1;
        if (op_i == OP_WRITE) begin
          val_d   = merge_bits(pb_rdata, w1_i, w2_i);
          state_d = ST_PWR;
        end else begin
          val_d   = pb_rdata;
          state_d = ST_MWR;
        end
      end
      ST_PWR:  if (pb_ack) state_d = ST_DONE;
      ST_MWR:  if (mw_ack) state_d = ST_DONE;
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      err_q   <= err_d;
    end
  end

  always_ff @(posedge clk) begin
    if (val_en) val_q <= val_d;
  end

  assign pb_req    = (state_q == ST_PRD) || (state_q == ST_PWR);
  assign pb_we     = (state_q == ST_PWR);
  assign pb_addr   = paddr_i;
  assign pb_wdata  = val_q;
  assign mw_req    = (state_q == ST_MWR);
  assign mw_addr   = {(mode_i ? w2_i[HI_W-1:0] : {HI_W{1'b0}}), w1_i};
  assign mw_data   = val_q;
  assign done      = (state_q == ST_DONE);
  assign release_o = done;
  assign err       = err_q;

  AST_PB_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    pb_req && !pb_ack |=> pb_req && $stable(pb_addr) && $stable(pb_we) && $stable(pb_wdata)); // R12
  AST_MW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mw_req && !mw_ack |=> mw_req && $stable(mw_addr) && $stable(mw_data)); // R12
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R10
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err); // R9
  AST_FULLMASK_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
    pb_req && !pb_we && (op_i == OP_WRITE) |-> !(&w2_i)); // R4
  AST_ONE_PORT: assert property (@(posedge clk) disable iff (!rst_n)
    !(pb_req && mw_req)); // R5
  AST_READ_NO_PWR: assert property (@(posedge clk) disable iff (!rst_n)
    pb_req && pb_we |-> op_i == OP_WRITE); // R5

endmodule

// File: rtl/cmd_elem_exec.sv
module cmd_elem_exec
  import cex_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int PADDR_W = 24,
  parameter int MADDR_W = 36
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ext_addr_mode,
  input  logic [DATA_W-1:0]  in_data,
  input  logic               in_valid,
  output logic               in_ready,
  output logic               pb_req,
  output logic               pb_we,
  output logic [PADDR_W-1:0] pb_addr,
  output logic [DATA_W-1:0]  pb_wdata,
  input  logic [DATA_W-1:0]  pb_rdata,
  input  logic               pb_ack,
  output logic               mw_req,
  output logic [MADDR_W-1:0] mw_addr,
  output logic [DATA_W-1:0]  mw_data,
  input  logic               mw_ack,
  output logic               done,
  output logic               err
);

  logic               elem_valid, release_s, mode_s;
  logic [OP_W-1:0]    op_s;
  logic [PADDR_W-1:0] paddr_s;
  logic [DATA_W-1:0]  w1_s, w2_s;

  cex_gather #(.DATA_W(DATA_W), .PADDR_W(PADDR_W)) u_gather (
    .clk(clk), .rst_n(rst_n), .ext_mode_i(ext_addr_mode),
    .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready),
    .release_i(release_s), .elem_valid_o(elem_valid),
    .op_o(op_s), .paddr_o(paddr_s), .w1_o(w1_s), .w2_o(w2_s), .mode_o(mode_s)
  );

  cex_exec #(.DATA_W(DATA_W), .PADDR_W(PADDR_W), .MADDR_W(MADDR_W)) u_exec (
    .clk(clk), .rst_n(rst_n), .elem_valid_i(elem_valid),
    .op_i(op_s), .paddr_i(paddr_s), .w1_i(w1_s), .w2_i(w2_s), .mode_i(mode_s),
    .pb_req(pb_req), .pb_we(pb_we), .pb_addr(pb_addr), .pb_wdata(pb_wdata),
    .pb_rdata(pb_rdata), .pb_ack(pb_ack),
    .mw_req(mw_req), .mw_addr(mw_addr), .mw_data(mw_data), .mw_ack(mw_ack),
    .release_o(release_s), .done(done), .err(err)
  );

  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (pb_req || mw_req || done) |-> !in_ready); // R1

endmodule

// File: tb/sim_cmd_elem_exec.sv
module sim_cmd_elem_exec;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        ext_addr_mode;
  logic [31:0] in_data;
  logic        in_valid;
  logic        in_ready;
  logic        pb_req, pb_we;
  logic [23:0] pb_addr;
  logic [31:0] pb_wdata, pb_rdata;
  logic        pb_ack;
  logic        mw_req;
  logic [35:0] mw_addr;
  logic [31:0] mw_data;
  logic        mw_ack;
  logic        done, err;

  always #5 clk = ~clk;

  cmd_elem_exec u0 (
    .clk(clk), .rst_n(rst_n), .ext_addr_mode(ext_addr_mode),
    .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready),
    .pb_req(pb_req), .pb_we(pb_we), .pb_addr(pb_addr), .pb_wdata(pb_wdata),
    .pb_rdata(pb_rdata), .pb_ack(pb_ack),
    .mw_req(mw_req), .mw_addr(mw_addr), .mw_data(mw_data), .mw_ack(mw_ack),
    .done(done), .err(err)
  );

  int tests = 0, fails = 0;
  bit finished = 0;

  logic [31:0] regs [16];
  int n_prd, n_pwr, n_mw, donecnt, dbl_done;
  logic [23:0] prd_addr, pwr_addr;
  logic [35:0] mw_addr_seen;
  logic [31:0] mw_data_seen;
  logic prev_done;
  bit exp_err;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] merged(input logic [31:0] o, input logic [31:0] d, input logic [31:0] m);
    return (o & ~m) | (d & m);
  endfunction

  // peripheral responder
  always @(negedge clk) begin
    pb_ack <= 1'b0;
    if (rst_n && pb_req && !pb_ack && ($urandom % 3 == 0)) begin
      pb_ack <= 1'b1;
      if (pb_we) begin
        regs[pb_addr[3:0]] = pb_wdata;
        n_pwr++;
        pwr_addr = pb_addr;
      end else begin
        pb_rdata <= regs[pb_addr[3:0]];
        n_prd++;
        prd_addr = pb_addr;
      end
    end
  end

  // memory responder and done monitor
  always @(negedge clk) begin
    mw_ack <= 1'b0;
    if (rst_n && mw_req && !mw_ack && ($urandom % 2 == 0)) begin
      mw_ack <= 1'b1;
      n_mw++;
      mw_addr_seen = mw_addr;
      mw_data_seen = mw_data;
    end
    if (rst_n && done) donecnt++;
    if (rst_n && done && prev_done) dbl_done++;
    prev_done = rst_n && done;
  end

  task automatic run_elem(input logic [31:0] w0, w1, w2, w3, input bit mode0, mode1);
    logic [31:0] old, exp_val, wv[4];
    logic [35:0] exp_ma;
    int d0, t;
    bit full;
    wv[0] = w0; wv[1] = w1; wv[2] = w2; wv[3] = w3;
    old = regs[w0[3:0]];
    n_prd = 0; n_pwr = 0; n_mw = 0;
    d0 = donecnt;
    @(negedge clk);
    ext_addr_mode = mode0;
    for (int i = 0; i < 4; i++) begin
      in_valid = 1'b1;
      in_data  = wv[i];
      while (!in_ready) @(negedge clk);
      @(negedge clk);
      if (i == 0) ext_addr_mode = mode1;
    end
    in_valid = 1'b0;
    in_data  = $urandom;
    chk(in_ready == 1'b0, "R1 ready low after word3", {63'd0, in_ready}, 64'd0);
    t = 0;
    while (donecnt == d0 && t < 200) begin @(negedge clk); t++; end
    chk(donecnt == d0 + 1, "R10 done count", donecnt, d0 + 1);
    if (w0[31:24] == 8'd0) begin
      full = &w2;
      exp_val = full ? w1 : merged(old, w1, w2);
      chk(regs[w0[3:0]] == exp_val, full ? "R4 register value" : "R3 register value",
          regs[w0[3:0]], exp_val);
      chk(n_prd == (full ? 0 : 1), full ? "R4 no read" : "R3 one read", n_prd, full ? 0 : 1);
      chk(n_pwr == 1 && n_mw == 0, "R3 one write, no memory", n_pwr * 16 + n_mw, 16);
      chk(pwr_addr == w0[23:0], "R2 write address", pwr_addr, w0[23:0]);
      if (!full)
        chk(prd_addr == w0[23:0], "R2 read address", prd_addr, w0[23:0]);
    end else if (w0[31:24] == 8'd1) begin
      exp_ma = {(mode0 ? w2[3:0] : 4'd0), w1};
      chk(n_prd == 1 && n_pwr == 0 && n_mw == 1, "R5 access counts",
          n_prd * 256 + n_pwr * 16 + n_mw, 257);
      chk(prd_addr == w0[23:0], "R2 read address", prd_addr, w0[23:0]);
      chk(mw_data_seen == old, "R5 memory data", mw_data_seen, old);
      chk(mw_addr_seen == exp_ma, mode0 ? "R6 R11 extended address" : "R7 R11 legacy address",
          mw_addr_seen, exp_ma);
    end else begin
      exp_err = 1'b1;
      chk(n_prd + n_pwr + n_mw == 0, "R9 no access on bad opcode", n_prd + n_pwr + n_mw, 0);
    end
    chk(err == exp_err, "R9 error flag", err, exp_err);
    @(negedge clk);
    chk(in_ready == 1'b1, "R1 ready after done", in_ready, 1);
    chk(donecnt == d0 + 1 && dbl_done == 0, "R10 single pulse", donecnt, d0 + 1);
  endtask

  task automatic rd_pair(input logic [31:0] w0, w1, w2, input bit m);
    logic [35:0] a0;
    logic [31:0] d0;
    run_elem(w0, w1, w2, 32'h0, m, m);
    a0 = mw_addr_seen; d0 = mw_data_seen;
    run_elem(w0, w1, w2, 32'hFFFF_FFFF, m, m);
    chk(mw_addr_seen == a0 && mw_data_seen == d0, "R8 word3 ignored", mw_addr_seen, a0);
  endtask

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 16; i++) regs[i] = $urandom;
    n_prd = 0; n_pwr = 0; n_mw = 0; donecnt = 0; dbl_done = 0;
    prev_done = 0; exp_err = 0;
    pb_ack = 0; mw_ack = 0; pb_rdata = 0;
    rst_n = 0; in_valid = 0; in_data = 0; ext_addr_mode = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(in_ready && !pb_req && !mw_req && !done && !err, "R1 reset state",
        {59'd0, in_ready, pb_req, mw_req, done, err}, 64'h10);
    // directed corners
    run_elem(32'h00AB_CD03, 32'h1234_5678, 32'hFFFF_FFFF, 32'hDEAD_BEEF, 0, 0);
    run_elem(32'h0000_0005, 32'hFFFF_FFFF, 32'h0000_0000, 32'h0, 1, 1);
    run_elem(32'h0055_AA07, 32'hA5A5_A5A5, 32'h0F0F_00FF, 32'h1, 1, 0);
    run_elem(32'h01FF_FF02, 32'h8000_0010, 32'hFFFF_FFF5, 32'h2, 1, 1);
    run_elem(32'h0100_0004, 32'h4000_0020, 32'hFFFF_FFFA, 32'h3, 0, 0);
    run_elem(32'h0112_3409, 32'h0000_1000, 32'h0000_0003, 32'h0, 1, 0);
    run_elem(32'h0112_340A, 32'h0000_2000, 32'h0000_000C, 32'h0, 0, 1);
    rd_pair(32'h0100_000B, 32'hCAFE_0000, 32'h1234_5679, 1);
    run_elem(32'h0200_0001, 32'h0, 32'h0, 32'h0, 0, 0);
    run_elem(32'hFF00_0001, 32'h0, 32'hFFFF_FFFF, 32'h0, 1, 1);
    // random
    for (int k = 0; k < 300; k++) begin
      logic [31:0] w0, w2;
      int sel;
      sel = $urandom % 10;
      w0 = {(sel < 4) ? 8'd0 : (sel < 9) ? 8'd1 : 8'($urandom % 254 + 2), 24'($urandom)};
      w2 = ($urandom % 4 == 0) ? 32'hFFFF_FFFF : $urandom;
      run_elem(w0, $urandom, w2, $urandom, 1'($urandom), 1'($urandom));
    end
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #1500000;
    if (!finished) begin
      tests++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule